// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block lets a host drive an 8-bit asynchronous NAND flash through a few registers. The host writes the column, row, data, address-size and strobe-timing registers. It then writes one 32-bit control word. The engine runs the flash bus cycles that word asks for: an opening opcode, column address bytes, row address bytes, a closing opcode and a data transfer of one to four bytes. It drives the latch enables, the chip enable and the write and read strobes. When the data phase is over, it waits a programmed delay and then watches the flash ready/busy line.

A phase whose flag is clear is skipped, and the remaining phases always run in the same order. A hold flag keeps the chip enable low after an operation ends, so that one flash transaction can be spread over several host operations. The last operation of the burst is issued with the flag clear, and that releases the chip enable. When the engine finishes, it clears the start bit and sets a ready bit. If the flash stays busy too long it also sets an error bit. The next accepted start clears both bits.

The controller states are IDLE, SETUP (latch-enable setup), STROBE_LO, STROBE_HI, HOLD (latch-enable hold), LONG_WAIT, POLL and FINISH. The transitions are:
- IDLE→SETUP on start when any phase is enabled, and IDLE→LONG_WAIT when no phase is enabled.
- SETUP→STROBE_LO, then STROBE_LO→STROBE_HI.
- STROBE_HI→STROBE_LO for the next byte of the same phase.
- STROBE_HI→HOLD after the last byte of an opcode or address phase, and STROBE_HI→LONG_WAIT after the last data byte.
- HOLD→SETUP for the next enabled phase, or HOLD→LONG_WAIT when no phase is left.
- LONG_WAIT→POLL.
- POLL→FINISH when ready is seen or the timeout expires.
- FINISH→IDLE.

Top module: `nand_seq_engine`

## Requirements
- R1: After reset the engine is idle. Chip enable, write strobe and read strobe are high, both latch enables are low, the data bus is not driven, and the control word reads back as 0.
- R2: The register addresses are: 0 control, 1 column, 2 row, 3 data, 4 address config, 5 wait counts. In the control word, bit 16 enables the first opcode, bit 17 the column bytes, bit 18 the row bytes, bit 19 the second opcode, bit 20 a data read and bit 21 a data write. The phases run in that order and a disabled phase emits no strobe. Opcode strobes have CLE high and ALE low. Address strobes have ALE high and CLE low. Data strobes have both low.
- R3: Address config bits 5:4 hold the column byte count minus one, and bits 7:6 hold the row byte count minus one. Address bytes are sent least significant byte first.
- R4: The first opcode byte comes from control bits 7:0, and the second opcode byte comes from control bits 15:8.
- R5: Control bits 29:28 hold the data byte count minus one. A write sends data register bytes starting from bits 7:0.
- R6: A read stores each byte taken from the flash while the read strobe is low into the data register, the first byte in bits 7:0. With a count of one, only bits 7:0 change.
- R7: A control write with bit 31 set starts an operation. Bit 31 reads back as 1 while the operation runs, and it clears when the operation finishes.
- R8: The wait register holds the strobe-low width in cycles in bits 5:0 and the high width in bits 11:6. The latch-enable setup is in bits 17:12 and the hold in bits 23:18. Bits 31:24 hold the delay before ready polling. A value of 0 counts as 1.
- R9: Chip enable is low for the whole of an operation. After the operation it stays low if control bit 30 was set, and it goes high if bit 30 was clear.
- R10: After the delay, the engine finishes as soon as the ready/busy input is high. If the input is still low after TIMEOUT_CYCLES poll cycles, bit 27 (error) is set together with bit 26 (ready). An accepted start clears both bits.
- R11: A control write that arrives while bit 31 still reads 1 is ignored. It changes neither the running sequence nor the stored control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register address for both reads and writes |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Contents of the addressed register |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven onto the flash bus |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Byte driven by the flash |
| nand_rb | input | 1 | Flash ready (1) or busy (0) |

## Verification
The sequencer is exercised with several control-word patterns:
- A full write: opcode, two column bytes, three row bytes and four data bytes. This separates byte order and address-count decoding.
- A four-byte read framed by both opcodes with one-byte addresses. This shows that the second opcode lands after the row bytes and that the flash bytes reach the correct register lanes.
- A single-byte read with the hold flag, followed by an operation that runs only the closing opcode. This tells phase skipping apart from the fixed order, and shows chip enable held and then released.
- A run with ready/busy held low. This shows the error path and the clearing of status on restart.
- A second control write while the engine is busy. This checks that the write is ignored.

Strobe low widths and the latch-enable setup are measured against two different wait settings.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_LO, ST_HI, ST_HOLD, ST_LONG, ST_POLL, ST_FINISH
    } seq_state_t;

    typedef enum logic [2:0] {
        PH_CMD1, PH_COL, PH_ROW, PH_CMD2, PH_DATA
    } seq_phase_t;

    localparam int BIT_OP1  = 16;
    localparam int BIT_COLA = 17;
    localparam int BIT_ROWA = 18;
    localparam int BIT_OP2  = 19;
    localparam int BIT_RD   = 20;
    localparam int BIT_WR   = 21;
    localparam int BIT_RDY  = 26;
    localparam int BIT_ERR  = 27;
    localparam int BIT_HOLD = 30;
    localparam int BIT_GO   = 31;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_COL  = 3'd1;
    localparam logic [2:0] RA_ROW  = 3'd2;
    localparam logic [2:0] RA_DATA = 3'd3;
    localparam logic [2:0] RA_CONF = 3'd4;
    localparam logic [2:0] RA_WAIT = 3'd5;

endpackage

// File: rtl/nseq_timer.sv
module nseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= (len == '0) ? '0 : len - 1'b1;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nseq_fsm.sv
module nseq_fsm
    import nseq_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic [31:0] ctrl,
    input  logic [7:0]  conf,
    input  logic [31:0] waitc,
    input  logic [31:0] col,
    input  logic [31:0] row,
    input  logic [31:0] data,
    input  logic        rb,
    output logic        cle,
    output logic        ale,
    output logic        we_n,
    output logic        re_n,
    output logic [7:0]  dq_out,
    output logic        dq_oe,
    output logic        cap_en,
    output logic [1:0]  cap_idx,
    output logic        fin,
    output logic        fin_err
);
    localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

    seq_state_t st_q, st_d;
    seq_phase_t ph_q, ph_d;
    logic [1:0]    idx_q, idx_d;
    logic [TW-1:0] tmo_q;
    logic          to_q;
    logic [4:0]    en;
    logic [1:0]    len_m1;
    logic          last, tdone, tload, rd_mode, act;
    logic          first_ok, next_ok;
    seq_phase_t first_ph, next_ph;
    logic [7:0]    tval;

    assign en      = {ctrl[BIT_RD] | ctrl[BIT_WR], ctrl[BIT_OP2], ctrl[BIT_ROWA],
                      ctrl[BIT_COLA], ctrl[BIT_OP1]};
    assign rd_mode = ctrl[BIT_RD];

    always_comb begin
        unique case (ph_q)
            PH_COL:  len_m1 = conf[5:4];
            PH_ROW:  len_m1 = conf[7:6];
            PH_DATA: len_m1 = ctrl[29:28];
            default: len_m1 = 2'd0;
        endcase
    end
    assign last = (idx_q == len_m1);

    always_comb begin
        first_ok = 1'b0; first_ph = PH_CMD1;
        next_ok  = 1'b0; next_ph  = PH_CMD1;
        for (int i = 4; i >= 0; i--) begin
            if (en[i]) begin
                first_ok = 1'b1;
                first_ph = seq_phase_t'(3'(i));
            end
            if (en[i] && (i > int'(ph_q))) begin
                next_ok = 1'b1;
                next_ph = seq_phase_t'(3'(i));
            end
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        ph_d  = ph_q;
        idx_d = idx_q;
        unique case (st_q)
            ST_IDLE: if (go) begin
                idx_d = 2'd0;
                if (first_ok) begin
                    st_d = ST_SETUP;
                    ph_d = first_ph;
                end else begin
                    st_d = ST_LONG;
                end
            end
            ST_SETUP: if (tdone) st_d = ST_LO;
            ST_LO:    if (tdone) st_d = ST_HI;
            ST_HI: if (tdone) begin
                if (!last) begin
                    st_d  = ST_LO;
                    idx_d = idx_q + 2'd1;
                end else if (ph_q == PH_DATA) begin
                    st_d = ST_LONG;
                end else begin
                    st_d = ST_HOLD;
                end
            end
            ST_HOLD: if (tdone) begin
                if (next_ok) begin
                    st_d  = ST_SETUP;
                    ph_d  = next_ph;
                    idx_d = 2'd0;
                end else begin
                    st_d = ST_LONG;
                end
            end
            ST_LONG: if (tdone) st_d = ST_POLL;
            ST_POLL: if (rb || (tmo_q == TW'(TIMEOUT_CYCLES - 1))) st_d = ST_FINISH;
            ST_FINISH: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            ph_q  <= PH_CMD1;
            idx_q <= 2'd0;
            tmo_q <= '0;
            to_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            ph_q  <= ph_d;
            idx_q <= idx_d;
            tmo_q <= (st_q == ST_POLL) ? tmo_q + 1'b1 : '0;
            if (st_q == ST_IDLE)
                to_q <= 1'b0;
            else if (st_q == ST_POLL && st_d == ST_FINISH && !rb)
                to_q <= 1'b1;
        end
    end

    always_comb begin
        unique case (st_d)
            ST_SETUP: tval = {2'b00, waitc[17:12]};
            ST_LO:    tval = {2'b00, waitc[5:0]};
            ST_HI:    tval = {2'b00, waitc[11:6]};
            ST_HOLD:  tval = {2'b00, waitc[23:18]};
            ST_LONG:  tval = waitc[31:24];
            default:  tval = 8'd0;
        endcase
    end
    assign tload = (st_d != st_q) || (st_q == ST_IDLE);

    nseq_timer #(.W(8)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tload),
        .len     (tval),
        .expired (tdone)
    );

    // outputs
    always_comb begin
        act     = (st_q == ST_SETUP) || (st_q == ST_LO) || (st_q == ST_HI) || (st_q == ST_HOLD);
        cle     = act && (ph_q == PH_CMD1 || ph_q == PH_CMD2);
        ale     = act && (ph_q == PH_COL  || ph_q == PH_ROW);
        we_n    = !(st_q == ST_LO && !(ph_q == PH_DATA && rd_mode));
        re_n    = !(st_q == ST_LO &&  (ph_q == PH_DATA && rd_mode));
        dq_oe   = act && !(ph_q == PH_DATA && rd_mode);
        cap_en  = (st_q == ST_LO) && tdone && (ph_q == PH_DATA) && rd_mode;
        cap_idx = idx_q;
        fin     = (st_q == ST_FINISH);
        fin_err = to_q;
        unique case (ph_q)
            PH_CMD1: dq_out = ctrl[7:0];
            PH_CMD2: dq_out = ctrl[15:8];
            PH_COL:  dq_out = col[8*idx_q +: 8];
            PH_ROW:  dq_out = row[8*idx_q +: 8];
            default: dq_out = data[8*idx_q +: 8];
        endcase
    end
endmodule

// File: rtl/nand_seq_engine.sv
module nand_seq_engine
    import nseq_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [2:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_ce_n,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_dq_out,
    output logic        nand_dq_oe,
    input  logic [7:0]  nand_dq_in,
    input  logic        nand_rb
);
    logic [31:0] ctrl_q, col_q, row_q, data_q, wait_q;
    logic [7:0]  conf_q;
    logic        start_q, rdy_q, err_q, hold_q;
    logic        cap_en, fin, fin_err, ctrl_take;
    logic [1:0]  cap_idx;

    assign ctrl_take = host_wr && (host_addr == RA_CTRL) && !start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0; col_q <= '0; row_q <= '0; data_q <= '0;
            wait_q <= '0; conf_q <= '0;
            start_q <= 1'b0; rdy_q <= 1'b0; err_q <= 1'b0; hold_q <= 1'b0;
        end else begin
            if (ctrl_take) begin
                ctrl_q <= host_wdata;
                if (host_wdata[BIT_GO]) begin
                    start_q <= 1'b1;
                    rdy_q   <= 1'b0;
                    err_q   <= 1'b0;
                end
            end else if (fin) begin
                start_q <= 1'b0;
                rdy_q   <= 1'b1;
                err_q   <= fin_err;
                hold_q  <= ctrl_q[BIT_HOLD];
            end
            if (host_wr) begin
                unique case (host_addr)
                    RA_COL:  col_q  <= host_wdata;
                    RA_ROW:  row_q  <= host_wdata;
                    RA_DATA: data_q <= host_wdata;
                    RA_CONF: conf_q <= host_wdata[7:0];
                    RA_WAIT: wait_q <= host_wdata;
                    default: ;
                endcase
            end
            if (cap_en)
                data_q[8*cap_idx +: 8] <= nand_dq_in;
        end
    end

    always_comb begin
        unique case (host_addr)
            RA_CTRL: host_rdata = {start_q, ctrl_q[30:28], err_q, rdy_q, ctrl_q[25:0]};
            RA_COL:  host_rdata = col_q;
            RA_ROW:  host_rdata = row_q;
            RA_DATA: host_rdata = data_q;
            RA_CONF: host_rdata = {24'd0, conf_q};
            RA_WAIT: host_rdata = wait_q;
            default: host_rdata = '0;
        endcase
    end

    assign nand_ce_n = !(start_q || hold_q);

    nseq_fsm #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (start_q),
        .ctrl    (ctrl_q),
        .conf    (conf_q),
        .waitc   (wait_q),
        .col     (col_q),
        .row     (row_q),
        .data    (data_q),
        .rb      (nand_rb),
        .cle     (nand_cle),
        .ale     (nand_ale),
        .we_n    (nand_we_n),
        .re_n    (nand_re_n),
        .dq_out  (nand_dq_out),
        .dq_oe   (nand_dq_oe),
        .cap_en  (cap_en),
        .cap_idx (cap_idx),
        .fin     (fin),
        .fin_err (fin_err)
    );
endmodule

// File: rtl/nseq_checks.sv
module nseq_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic [2:0]  host_addr,
    input logic [31:0] host_wdata,
    input logic        cle,
    input logic        ale,
    input logic        ce_n,
    input logic        we_n,
    input logic        re_n,
    input logic        start,
    input logic        rdy,
    input logic        err,
    input logic [31:0] ctrl
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n)); // R2
    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale)); // R2
    AST_CE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> !ce_n); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !start |-> (we_n && re_n && !cle && !ale)); // R7
    AST_ERR_WITH_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> rdy); // R10
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 3'd0 && host_wdata[31] && !start) |=> (start && !rdy && !err)); // R10
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 3'd0 && start) |=> $stable(ctrl)); // R11
    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start) |-> rdy); // R7
endmodule

bind nand_seq_engine nseq_checks u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .cle        (nand_cle),
    .ale        (nand_ale),
    .ce_n       (nand_ce_n),
    .we_n       (nand_we_n),
    .re_n       (nand_re_n),
    .start      (start_q),
    .rdy        (rdy_q),
    .err        (err_q),
    .ctrl       (ctrl_q)
);

// File: tb/nand_seq_engine_tb.sv
module nand_seq_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        cle, ale, ce_n, we_n, re_n, dq_oe;
    logic [7:0]  dq_out;
    logic [7:0]  dq_in = 8'h00;
    logic        rb = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct packed {
        logic       cle;
        logic       ale;
        logic       rd;
        logic [7:0] b;
    } item_t;

    item_t      sb_q[$];
    logic [7:0] model_q[$];
    int         exp_lo = 1;
    int         exp_setup = 1;
    logic       seen_first = 1'b0;

    always #10 clk = ~clk;

    nand_seq_engine #(.TIMEOUT_CYCLES(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .nand_cle(cle),
        .nand_ale(ale), .nand_ce_n(ce_n), .nand_we_n(we_n), .nand_re_n(re_n),
        .nand_dq_out(dq_out), .nand_dq_oe(dq_oe), .nand_dq_in(dq_in), .nand_rb(rb)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic c, input logic a, input logic r, input logic [7:0] b);
        item_t it;
        it.cle = c; it.ale = a; it.rd = r; it.b = b;
        sb_q.push_back(it);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] v;
        v = 32'h8000_0000;
        while (v[31]) rd(3'd0, v);
    endtask

    task automatic launch(input logic [31:0] c);
        logic [31:0] v;
        seen_first = 1'b0;
        wr(3'd0, c);
        rd(3'd0, v);
        check(v[31] == 1'b1, "R7 start reads 1 while running", {31'd0, v[31]}, 32'd1);
        wait_done();
        check(sb_q.size() == 0, "R2 all expected strobes issued", sb_q.size(), 0);
    endtask

    // monitor: compares each completed strobe with the scoreboard
    logic       p_we = 1'b1, p_re = 1'b1;
    logic       l_cle, l_ale, l_rd;
    logic [7:0] l_b;
    int         lo_cnt = 0, su_cnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!re_n && model_q.size() > 0) dq_in = model_q[0];
            if (!seen_first && (cle || ale) && we_n && re_n) su_cnt++;
            if ((!we_n || !re_n) && p_we && p_re && !seen_first) begin
                seen_first = 1'b1;
                check(su_cnt == exp_setup, "R8 latch setup cycles", su_cnt, exp_setup);
                su_cnt = 0;
            end
            if (!we_n) begin
                l_cle = cle; l_ale = ale; l_rd = 1'b0; l_b = dq_out; lo_cnt++;
                check(dq_oe == 1'b1, "R2 bus driven during write strobe", {31'd0, dq_oe}, 32'd1);
            end
            if (!re_n) begin
                l_cle = cle; l_ale = ale; l_rd = 1'b1; l_b = dq_in; lo_cnt++;
            end
            if ((we_n && !p_we) || (re_n && !p_re)) begin
                check(lo_cnt == exp_lo, "R8 strobe low width", lo_cnt, exp_lo);
                lo_cnt = 0;
                if (!re_n || (re_n && !p_re)) begin
                    if (model_q.size() > 0) void'(model_q.pop_front());
                end
                if (sb_q.size() == 0) begin
                    check(1'b0, "R2 unexpected strobe", {20'd0, l_cle, l_ale, l_rd, l_b}, 0);
                end else begin
                    item_t e;
                    e = sb_q.pop_front();
                    check({l_cle, l_ale, l_rd, l_b} == e, "R2 R3 R4 R5 strobe cle/ale/rd/byte",
                          {21'd0, l_cle, l_ale, l_rd, l_b}, {21'd0, e});
                end
            end
            p_we = we_n;
            p_re = re_n;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({ce_n, we_n, re_n, cle, ale, dq_oe} == 6'b111000, "R1 pins at reset",
              {26'd0, ce_n, we_n, re_n, cle, ale, dq_oe}, 32'h38);
        rd(3'd0, v);
        check(v == 32'd0, "R1 control reads 0", v, 0);
        rst_n = 1'b1;

        // full write: op1, 2 col, 3 row, 4 data bytes
        wr(3'd5, 32'h0304_1042);  // w0=2 w1=1 w2=1 w3=1 long=3
        wr(3'd4, 32'h0000_0090);  // row 3 bytes, col 2 bytes
        wr(3'd1, 32'h0000_1234);
        wr(3'd2, 32'h00AB_CDEF);
        wr(3'd3, 32'hA1B2_C3D4);
        exp_lo = 2; exp_setup = 1;
        push(1, 0, 0, 8'h80);
        push(0, 1, 0, 8'h34); push(0, 1, 0, 8'h12);
        push(0, 1, 0, 8'hEF); push(0, 1, 0, 8'hCD); push(0, 1, 0, 8'hAB);
        push(0, 0, 0, 8'hD4); push(0, 0, 0, 8'hC3); push(0, 0, 0, 8'hB2); push(0, 0, 0, 8'hA1);
        launch(32'hB027_0080);
        rd(3'd0, v);
        check(v[27:26] == 2'b01, "R7 ready set, no error", {30'd0, v[27:26]}, 32'd1);
        check(ce_n == 1'b1, "R9 chip enable released without hold", {31'd0, ce_n}, 32'd1);

        // four-byte read framed by both opcodes
        wr(3'd5, 32'h0304_2043);  // w0=3 w2=2
        wr(3'd4, 32'h0000_0000);
        exp_lo = 3; exp_setup = 2;
        model_q = '{8'h11, 8'h22, 8'h33, 8'h44};
        push(1, 0, 0, 8'h00); push(0, 1, 0, 8'h34); push(0, 1, 0, 8'hEF); push(1, 0, 0, 8'h30);
        push(0, 0, 1, 8'h11); push(0, 0, 1, 8'h22); push(0, 0, 1, 8'h33); push(0, 0, 1, 8'h44);
        launch(32'hB01F_3000);
        rd(3'd3, v);
        check(v == 32'h4433_2211, "R6 read bytes into data lanes", v, 32'h4433_2211);

        // single-byte read with chip-enable hold
        model_q = '{8'hE0};
        push(1, 0, 0, 8'h70); push(0, 0, 1, 8'hE0);
        launch(32'hC011_0070);
        rd(3'd3, v);
        check(v == 32'h4433_22E0, "R6 one-byte read touches only bits 7:0", v, 32'h4433_22E0);
        check(ce_n == 1'b0, "R9 chip enable held after op", {31'd0, ce_n}, 32'd0);

        // closing opcode only: first opcode skipped
        push(1, 0, 0, 8'h90);
        launch(32'h8008_9000);
        check(ce_n == 1'b1, "R9 chip enable released by final op", {31'd0, ce_n}, 32'd1);

        // busy never clears -> timeout error
        rb = 1'b0;
        push(1, 0, 0, 8'hFF);
        launch(32'h8001_00FF);
        rd(3'd0, v);
        check(v[27:26] == 2'b11, "R10 error and ready after timeout", {30'd0, v[27:26]}, 32'd3);
        rb = 1'b1;
        push(1, 0, 0, 8'hFF);
        seen_first = 1'b0;
        wr(3'd0, 32'h8001_00FF);
        rd(3'd0, v);
        check(v[31:26] == 6'b100000, "R10 start clears ready and error", {26'd0, v[31:26]}, 32'h20);
        wait_done();
        rd(3'd0, v);
        check(v[27:26] == 2'b01, "R10 ready without error when flash ready", {30'd0, v[27:26]}, 32'd1);

        // control write while busy is ignored
        rb = 1'b0;
        push(1, 0, 0, 8'h60);
        seen_first = 1'b0;
        wr(3'd0, 32'h8001_0060);
        wr(3'd0, 32'h801F_3399);
        rd(3'd0, v);
        check(v[31] == 1'b1, "R11 still busy after ignored write", {31'd0, v[31]}, 32'd1);
        wait_done();
        rb = 1'b1;
        rd(3'd0, v);
        check(v[23:0] == 24'h01_0060, "R11 stored control unchanged", {8'd0, v[23:0]}, 32'h0001_0060);
        check(sb_q.size() == 0, "R11 no extra strobes from ignored write", sb_q.size(), 0);

        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule